// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block maps addresses from a local bus into PCI bus addresses. It has three programmable windows. Each window is a pair of registers. The base register places the window in local address space, sets its size and enables it. The map register gives the PCI address bits above the window boundary, the cycle type, and how the two lowest PCI address bits are formed. A request is checked against every enabled window. The lowest-numbered window that contains the address supplies the result, so windows may overlap. The result is registered one cycle after the request. It carries a hit flag, the index of the winning window, a cycle-type code and the translated PCI address.

When a map register selects the configuration cycle type, the same datapath builds configuration addresses. For a type-0 cycle, the local offset carries the function number, the register number and the low device-select bits. Device-select bits above the window boundary come from the map register. For a type-1 cycle, the map register tells the block to pass the local A1:A0 through, which gives the trailing 01. The last window is reserved for PCI I/O.

Software rewrites the registers through a simple write port. A typical use is to enlarge window 0 so that it hides window 1, retarget window 1 at configuration space, and then restore both windows.

Top module: `lbpci_xlat`

## Requirements
- R1: After reset every window is disabled and the response outputs are low. A request made right after reset misses.
- R2: `rsp_valid` equals `req_valid` from the previous clock. All response fields belong to the request made one clock earlier.
- R3: Base register layout:
  - Bits 31:20 hold the window base.
  - Bits 7:4 hold a size code c; the window spans 2^(20+c) bytes. Codes above 9 act as 9 (512 MB), so code 4 gives 16 MB and code 8 gives 256 MB.
  - Bit 0 enables the window.
  
  An address hits an enabled window when its bits above the size boundary equal the same bits of the base. A disabled window never hits.
- R4: When several enabled windows hit, the lowest index wins.
- R5: Map register layout:
  - Bits 31:20 hold the PCI base.
  - Bits 3:1 hold the cycle type.
  - Bit 0 enables the low address bits.
  
  The translated address is the PCI base bits above the window boundary ORed with the local offset inside the window.
- R6: If map bit 0 is clear, PCI address bits 1:0 are 00. If it is set, they are copied from the local address.
- R7: Windows 0 and 1 output the map cycle type unchanged. Window 2 outputs I/O (3'b001), except that it outputs configuration (3'b101) when its map type is 3'b101.
- R8: A miss gives `rsp_hit`=0, `rsp_win`=0, `rsp_type`=3'b000 and `rsp_addr`=0.
- R9: A register write takes effect on the next clock edge. A request in the same cycle as the write uses the old contents.
- R10: A write whose index is 3 or higher changes no window.
- R11: With a configuration-type map on a 16 MB window, a device-select bit held in map bits 31:24 appears in the PCI address above the local offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Window index of the write |
| wr_map | input | 1 | 1 writes the map register, 0 writes the base register |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_win | output | 2 | Index of the winning window |
| rsp_type | output | 3 | Cycle-type code, 000 on a miss |
| rsp_addr | output | 32 | Translated PCI address |

## Verification
The hardest situation to reach is an overlap in which two differently sized windows both cover one address and the answer depends on priority rather than on size. The stimulus reaches it by growing window 0 from 256 MB to 512 MB over the top of window 1. It then moves window 1 into configuration space and makes window 2 larger than its base alignment, so that window 2 also overlaps window 1. A further case writes a register in the same cycle as a request. The response must still show the old window, and the request that follows must show the new one.

// File: rtl/lbpci_xlat_pkg.sv
package lbpci_xlat_pkg;
   typedef logic [2:0] cyc_t;

   localparam cyc_t CYC_NONE = 3'b000;
   localparam cyc_t CYC_IO   = 3'b001;
   localparam cyc_t CYC_CFG  = 3'b101;

   // base register fields
   localparam int BASE_EN_BIT = 0;
   localparam int SIZE_LSB    = 4;
   localparam int SIZE_W      = 4;

   // map register fields
   localparam int LOWEN_BIT   = 0;
   localparam int TYPE_LSB    = 1;
   localparam int TYPE_W      = 3;
endpackage

// File: rtl/lbpci_xlat_regs.sv
module lbpci_xlat_regs #(
   parameter int NWIN      = 3,
   parameter int AW        = 32,
   parameter int MIN_SHIFT = 20,
   parameter int IW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_map,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] base_q [NWIN],
   output logic [AW-1:0] map_q  [NWIN]
);
   import lbpci_xlat_pkg::*;

   localparam logic [AW-1:0] ONE   = AW'(1);
   localparam logic [AW-1:0] ALIGN = ~((ONE << MIN_SHIFT) - ONE);
   localparam logic [AW-1:0] SZ_F  = AW'(((1 << SIZE_W) - 1) << SIZE_LSB);
   localparam logic [AW-1:0] TY_F  = AW'(((1 << TYPE_W) - 1) << TYPE_LSB);
   localparam logic [AW-1:0] BASE_KEEP = ALIGN | SZ_F | (ONE << BASE_EN_BIT);
   localparam logic [AW-1:0] MAP_KEEP  = ALIGN | TY_F | (ONE << LOWEN_BIT);

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      logic sel;
      assign sel = wr_en && (wr_idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[i] <= '0;
            map_q[i]  <= '0;
         end else if (sel) begin
            if (wr_map) map_q[i]  <= wr_data & MAP_KEEP;
            else        base_q[i] <= wr_data & BASE_KEEP;
         end
      end
   end
endmodule

// File: rtl/lbpci_xlat_win.sv
module lbpci_xlat_win #(
   parameter int AW        = 32,
   parameter int MIN_SHIFT = 20,
   parameter int MAX_CODE  = 9,
   parameter bit IS_IO     = 1'b0
) (
   input  logic [AW-1:0]           base,
   input  logic [AW-1:0]           map,
   input  logic [AW-1:0]           addr,
   output logic                    hit,
   output logic [AW-1:0]           pci,
   output lbpci_xlat_pkg::cyc_t    typ
);
   import lbpci_xlat_pkg::*;

   localparam logic [AW-1:0] ONE   = AW'(1);
   localparam logic [AW-1:0] ALIGN = ~((ONE << MIN_SHIFT) - ONE);
   localparam logic [SIZE_W-1:0] CODE_CAP = SIZE_W'(MAX_CODE);

   logic [SIZE_W-1:0] code, eff;
   logic [7:0]        shamt;
   logic [AW-1:0]     mask, raw;
   cyc_t              map_ty;

   always_comb begin
      code  = base[SIZE_LSB +: SIZE_W];
      eff   = (code > CODE_CAP) ? CODE_CAP : code;
      shamt = 8'(MIN_SHIFT) + 8'(eff);
      mask  = (ONE << shamt) - ONE;
      hit   = base[BASE_EN_BIT] && ((addr & ~mask) == (base & ~mask));
      raw   = (map & ALIGN & ~mask) | (addr & mask);
      pci   = map[LOWEN_BIT] ? raw : {raw[AW-1:2], 2'b00};
      map_ty = map[TYPE_LSB +: TYPE_W];
   end

   if (IS_IO) begin : g_io
      assign typ = (map_ty == CYC_CFG) ? CYC_CFG : CYC_IO;
   end else begin : g_mem
      assign typ = map_ty;
   end
endmodule

// File: rtl/lbpci_xlat_pick.sv
module lbpci_xlat_pick #(
   parameter int NWIN = 3,
   parameter int AW   = 32,
   parameter int IW   = 2
) (
   input  logic [NWIN-1:0]         hit,
   input  logic [AW-1:0]           pci [NWIN],
   input  lbpci_xlat_pkg::cyc_t    typ [NWIN],
   output logic                    any,
   output logic [IW-1:0]           idx,
   output logic [AW-1:0]           addr,
   output lbpci_xlat_pkg::cyc_t    ty
);
   import lbpci_xlat_pkg::*;

   // descending scan: the last assignment is the lowest matching index
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      addr = '0;
      ty   = CYC_NONE;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any  = 1'b1;
            idx  = IW'(i);
            addr = pci[i];
            ty   = typ[i];
         end
      end
   end
endmodule

// File: rtl/lbpci_xlat.sv
module lbpci_xlat #(
   parameter int NWIN      = 3,
   parameter int AW        = 32,
   parameter int MIN_SHIFT = 20,
   parameter int MAX_CODE  = 9,
   parameter int IW        = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_map,
   input  logic [AW-1:0] wr_data,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          rsp_valid,
   output logic          rsp_hit,
   output logic [IW-1:0] rsp_win,
   output logic [2:0]    rsp_type,
   output logic [AW-1:0] rsp_addr
);
   import lbpci_xlat_pkg::*;

   if (NWIN < 1) begin : g_bad_nwin
      $error("lbpci_xlat: NWIN must be at least 1");
   end
   if (MIN_SHIFT < 8 || MIN_SHIFT + MAX_CODE >= AW) begin : g_bad_shift
      $error("lbpci_xlat: window sizes do not fit the address width");
   end
   if (MAX_CODE >= (1 << SIZE_W)) begin : g_bad_code
      $error("lbpci_xlat: MAX_CODE exceeds size field");
   end

   logic [AW-1:0] base_q [NWIN];
   logic [AW-1:0] map_q  [NWIN];
   logic [NWIN-1:0] hit_v;
   logic [AW-1:0] pci_v [NWIN];
   cyc_t          typ_v [NWIN];
   logic          sel_any;
   logic [IW-1:0] sel_idx;
   logic [AW-1:0] sel_addr;
   cyc_t          sel_ty;

   lbpci_xlat_regs #(.NWIN(NWIN), .AW(AW), .MIN_SHIFT(MIN_SHIFT), .IW(IW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_map(wr_map), .wr_data(wr_data), .base_q(base_q), .map_q(map_q)
   );

   for (genvar i = 0; i < NWIN; i++) begin : g_w
      lbpci_xlat_win #(
         .AW(AW), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE),
         .IS_IO((i == NWIN - 1) && (NWIN > 1))
      ) u_win (
         .base(base_q[i]), .map(map_q[i]), .addr(req_addr),
         .hit(hit_v[i]), .pci(pci_v[i]), .typ(typ_v[i])
      );
   end

   lbpci_xlat_pick #(.NWIN(NWIN), .AW(AW), .IW(IW)) u_pick (
      .hit(hit_v), .pci(pci_v), .typ(typ_v),
      .any(sel_any), .idx(sel_idx), .addr(sel_addr), .ty(sel_ty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_win   <= '0;
         rsp_type  <= CYC_NONE;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && sel_any;
         rsp_win   <= req_valid ? sel_idx  : '0;
         rsp_type  <= req_valid ? sel_ty   : CYC_NONE;
         rsp_addr  <= req_valid ? sel_addr : '0;
      end
   end
endmodule

// File: rtl/lbpci_xlat_chk.sv
module lbpci_xlat_chk #(
   parameter int NWIN = 3,
   parameter int AW   = 32,
   parameter int IW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          rsp_valid,
   input logic          rsp_hit,
   input logic [IW-1:0] rsp_win,
   input logic [2:0]    rsp_type,
   input logic [AW-1:0] rsp_addr
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> !rsp_valid);

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (rsp_valid == $past(req_valid)));

   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_type == 3'b000 && rsp_addr == '0 && rsp_win == '0));

   a_r4_win_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (32'(rsp_win) < NWIN));

   a_r7_last_window_type: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && 32'(rsp_win) == NWIN - 1 && NWIN > 1) |->
      (rsp_type == 3'b001 || rsp_type == 3'b101));

   a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
endmodule

bind lbpci_xlat lbpci_xlat_chk #(.NWIN(NWIN), .AW(AW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_type(rsp_type), .rsp_addr(rsp_addr)
);

// File: tb/sim_lbpci_xlat.sv
module sim_lbpci_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic        wr_map = 1'b0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [1:0]  rsp_win;
   logic [2:0]  rsp_type;
   logic [31:0] rsp_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lbpci_xlat u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_map(wr_map),
      .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
      .rsp_type(rsp_type), .rsp_addr(rsp_addr)
   );

   typedef struct packed {
      logic [31:0] a;
      logic        h;
      logic [1:0]  w;
      logic [2:0]  t;
      logic [31:0] p;
   } vec_t;

   // windows: 0 @4000_0000 256MB mem, 1 @5000_0000 256MB -> 1000_0000 low-en, 2 @6000_0000 16MB io
   localparam vec_t VEC [8] = '{
      '{32'h4123_4567, 1'b1, 2'd0, 3'b011, 32'h0123_4564},
      '{32'h5ABC_DEF3, 1'b1, 2'd1, 3'b110, 32'h1ABC_DEF3},
      '{32'h60FF_FFFF, 1'b1, 2'd2, 3'b001, 32'h00FF_FFFC},
      '{32'h6100_0000, 1'b0, 2'd0, 3'b000, 32'h0000_0000},
      '{32'h3FFF_FFFF, 1'b0, 2'd0, 3'b000, 32'h0000_0000},
      '{32'h4FFF_FFFF, 1'b1, 2'd0, 3'b011, 32'h0FFF_FFFC},
      '{32'h5000_0000, 1'b1, 2'd1, 3'b110, 32'h1000_0000},
      '{32'h6000_0001, 1'b1, 2'd2, 3'b001, 32'h0000_0000}
   };

   task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] idx, input logic m, input logic [31:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_map = m; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic req(input logic [31:0] a, input logic h, input logic [1:0] w,
                      input logic [2:0] t, input logic [31:0] p, input string tag);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, {rsp_valid, rsp_hit, rsp_win, rsp_type, rsp_addr}, {1'b1, h, w, t, p});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs quiet after reset
      check("R1 reset state", {rsp_valid, rsp_hit, rsp_win, rsp_type, rsp_addr}, 39'd0);
      // R1 R8: nothing enabled yet
      req(32'h4000_0000, 1'b0, 2'd0, 3'b000, 32'h0, "R1/R8 miss after reset");

      wr(2'd0, 1'b0, 32'h4000_0081);
      wr(2'd0, 1'b1, 32'h0000_0006);
      wr(2'd1, 1'b0, 32'h5000_0081);
      wr(2'd1, 1'b1, 32'h1000_000D);
      wr(2'd2, 1'b0, 32'h6000_0041);
      wr(2'd2, 1'b1, 32'h0000_0004);

      for (int i = 0; i < 8; i++)
         req(VEC[i].a, VEC[i].h, VEC[i].w, VEC[i].t, VEC[i].p, "R3/R5/R6/R7/R8 table");

      // R2: no request, no response
      @(negedge clk);
      check("R2 idle", {38'd0, rsp_valid}, 39'd0);

      // R4: window 0 grows to 512MB and shadows window 1
      wr(2'd0, 1'b0, 32'h4000_0091);
      req(32'h5000_0010, 1'b1, 2'd0, 3'b011, 32'h1000_0010, "R4 overlap");

      // R11: type-0 config, device select bit 24 from map
      wr(2'd1, 1'b0, 32'h6100_0041);
      wr(2'd1, 1'b1, 32'h0100_000A);
      req(32'h6100_0A0E, 1'b1, 2'd1, 3'b101, 32'h0100_0A0C, "R11 type0 cfg");

      // R6: type-1 keeps local A1:A0
      wr(2'd1, 1'b1, 32'h0000_000B);
      req(32'h6103_5A11, 1'b1, 2'd1, 3'b101, 32'h0003_5A11, "R6 type1 cfg");

      // R3 clamp of code 15 to 512MB, R7 config on last window
      wr(2'd2, 1'b0, 32'h6000_00F1);
      wr(2'd2, 1'b1, 32'h0000_000A);
      req(32'h7FFF_FFF0, 1'b1, 2'd2, 3'b101, 32'h1FFF_FFF0, "R3/R7 clamp");
      req(32'h6100_0004, 1'b1, 2'd1, 3'b101, 32'h0000_0004, "R4 window1 over window2");

      // R9: disable window 0 in the same cycle as a request
      wr_en = 1'b1; wr_idx = 2'd0; wr_map = 1'b0; wr_data = 32'h0;
      req_valid = 1'b1; req_addr = 32'h4000_0100;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      check("R9 old value", {rsp_valid, rsp_hit, rsp_win, rsp_type, rsp_addr},
            {1'b1, 1'b1, 2'd0, 3'b011, 32'h0000_0100});
      req(32'h4000_0100, 1'b0, 2'd0, 3'b000, 32'h0, "R9/R3 disabled now");

      // R10: out-of-range index is ignored
      wr(2'd3, 1'b0, 32'h4000_0081);
      req(32'h4000_0100, 1'b0, 2'd0, 3'b000, 32'h0, "R10 bad index");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule